// File: doc/BRIEF.md
# Predicated Vector Multiply-Add Unit

This is a single-stage SIMD execution unit for a 128-bit vector datapath. Each operation takes a 32-bit instruction word, three 128-bit operand vectors and a 16-bit governing predicate. It decodes four predicated multiply-accumulate forms and computes, in every active element lane, an addend plus or minus the product of two multiplicands. The element width is chosen per instruction as 8, 16, 32 or 64 bits.

The register fields of the instruction word are decoded combinationally. This lets an external register file read the right operands in the same cycle. The operands are `zd_i`, which is the prior contents of the destination; `zs_i`, which is the register named by bits 9:5; and `zm_i`. The instruction's role bits say whether the destination acts as the addend or as the multiplicand.

The result is registered one cycle after a valid/ready acceptance. It comes with a write enable and the destination index. Words that do not decode are flagged as illegal, and they leave the destination untouched.

Top module: `vmadd_unit`

## Requirements
- R1: A word is legal only when bits 31:24 equal 8'h04, bit 21 is 0 and bits 15:13 are one of 010, 011, 110 or 111. For any other word, `dec_illegal_o` is 1. When such a word completes, `illegal_o` is 1, `wr_en_o` is 0 and `result_o` equals `zd_i`.
- R2: `dec_rd_o`, `dec_rs_o`, `dec_rm_o` and `dec_pg_o` follow instruction bits 4:0, 9:5, 20:16 and 12:10 respectively. `dec_role_o[0]` is 1 for subtract (bit 13). `dec_role_o[1]` is 1 when the destination is the multiplicand (bit 15).
- R3: Bits 23:22 select the lane width: 0 gives 8 bits, 1 gives 16, 2 gives 32 and 3 gives 64.
- R4: Opcode 010 gives `zd + zs*zm` in each active lane, keeping the low lane-width bits with modular wrap.
- R5: Opcode 011 gives `zd - zs*zm` in each active lane, with modular wrap.
- R6: Opcode 110 gives `zs + zd*zm`. Opcode 111 gives `zs - zd*zm`.
- R7: A lane is active only when the predicate bit of its lowest-addressed byte is 1. The other predicate bits inside that lane have no effect.
- R8: Inactive lanes output the `zd_i` value of that lane.
- R9: Lane 0 occupies the least significant bits of every vector, and predicate bit 0 belongs to byte 0.
- R10: `in_ready_o` is 1 when no result is pending or when the pending result is being taken. After an acceptance, `out_valid_o` is 1 in the next cycle. A pending result stays stable while `out_ready_i` is 0.
- R11: After reset, `out_valid_o` and `wr_en_o` are 0 and `in_ready_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| in_valid_i | input | 1 | Operation offered |
| in_ready_o | output | 1 | Operation can be accepted |
| insn_i | input | 32 | Instruction word |
| zd_i | input | 128 | Prior destination contents |
| zs_i | input | 128 | Register named by bits 9:5 |
| zm_i | input | 128 | Register named by bits 20:16 |
| pred_i | input | 16 | Governing predicate, one bit per byte |
| dec_rd_o | output | 5 | Decoded destination index |
| dec_rs_o | output | 5 | Decoded bits 9:5 register index |
| dec_rm_o | output | 5 | Decoded m register index |
| dec_pg_o | output | 3 | Decoded predicate register index |
| dec_role_o | output | 2 | Bit 1: destination is multiplicand; bit 0: subtract |
| dec_illegal_o | output | 1 | Current word does not decode |
| out_valid_o | output | 1 | Result pending |
| out_ready_i | input | 1 | Result consumer ready |
| result_o | output | 128 | Result vector |
| wr_en_o | output | 1 | Result should be written back |
| illegal_o | output | 1 | Completed word did not decode |
| wr_rd_o | output | 5 | Destination index of the result |

## Verification
A new operation can be accepted in the same cycle as a pending result is drained. The bench provokes this by holding `out_ready_i` low so that one result waits. While it waits, the bench offers a second word and expects `in_ready_o` low and the result unchanged. It then raises `out_ready_i`, and the first result retires while the second is captured on the same edge. The next sample must show the second result with its own write enable. All lane results are judged against hand-computed vectors. These include wrap in every width, lane-0 placement and predicate bits that sit inside a lane but must be ignored.

// File: rtl/vmadd_pkg.sv
package vmadd_pkg;
  localparam int unsigned ILEN = 32;

  typedef enum logic [1:0] {
    ESZ_B = 2'd0,
    ESZ_H = 2'd1,
    ESZ_S = 2'd2,
    ESZ_D = 2'd3
  } esz_e;

  typedef struct packed {
    logic dst_mul;
    logic sub;
  } role_t;

  typedef struct packed {
    logic       legal;
    esz_e       esz;
    role_t      role;
    logic [4:0] rd;
    logic [4:0] rs;
    logic [4:0] rm;
    logic [2:0] pg;
  } dec_t;
endpackage

// File: rtl/vmadd_decode.sv
module vmadd_decode
  import vmadd_pkg::*;
(
  input  logic [ILEN-1:0] insn_i,
  output dec_t            dec_o
);
  logic [2:0] op;
  logic       fixed_ok;

  assign op       = insn_i[15:13];
  assign fixed_ok = (insn_i[31:24] == 8'h04) && !insn_i[21];

  always_comb begin
    dec_o              = '0;
    dec_o.rd           = insn_i[4:0];
    dec_o.rs           = insn_i[9:5];
    dec_o.rm           = insn_i[20:16];
    dec_o.pg           = insn_i[12:10];
    dec_o.esz          = esz_e'(insn_i[23:22]);
    dec_o.role.sub     = op[0];
    dec_o.role.dst_mul = op[2];
    // legal opcodes: 010, 011, 110, 111
    dec_o.legal        = fixed_ok && op[1];
  end
endmodule

// File: rtl/vmadd_lane.sv
module vmadd_lane #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] add_i,
  input  logic [W-1:0] n_i,
  input  logic [W-1:0] m_i,
  input  logic         sub_i,
  output logic [W-1:0] res_o
);
  logic [W-1:0] prod;

  assign prod  = n_i * m_i;
  assign res_o = sub_i ? (add_i - prod) : (add_i + prod);
endmodule

// File: rtl/vmadd_vec.sv
module vmadd_vec #(
  parameter int unsigned VLEN = 128,
  parameter int unsigned W    = 8
) (
  input  logic [VLEN-1:0]   add_i,
  input  logic [VLEN-1:0]   n_i,
  input  logic [VLEN-1:0]   m_i,
  input  logic [VLEN-1:0]   old_i,
  input  logic [VLEN/8-1:0] pred_i,
  input  logic              sub_i,
  output logic [VLEN-1:0]   res_o
);
  localparam int unsigned NL  = VLEN / W;
  localparam int unsigned BPL = W / 8;

  for (genvar l = 0; l < NL; l++) begin : g_lane
    logic [W-1:0] lane_res;

    vmadd_lane #(.W(W)) u_lane (
      .add_i (add_i[l*W +: W]),
      .n_i   (n_i[l*W +: W]),
      .m_i   (m_i[l*W +: W]),
      .sub_i (sub_i),
      .res_o (lane_res)
    );

    // only the lowest byte's predicate bit gates the lane
    assign res_o[l*W +: W] = pred_i[l*BPL] ? lane_res : old_i[l*W +: W];
  end
endmodule

// File: rtl/vmadd_unit.sv
module vmadd_unit
  import vmadd_pkg::*;
#(
  parameter int unsigned VLEN = 128
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [ILEN-1:0]   insn_i,
  input  logic [VLEN-1:0]   zd_i,
  input  logic [VLEN-1:0]   zs_i,
  input  logic [VLEN-1:0]   zm_i,
  input  logic [VLEN/8-1:0] pred_i,
  output logic [4:0]        dec_rd_o,
  output logic [4:0]        dec_rs_o,
  output logic [4:0]        dec_rm_o,
  output logic [2:0]        dec_pg_o,
  output logic [1:0]        dec_role_o,
  output logic              dec_illegal_o,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [VLEN-1:0]   result_o,
  output logic              wr_en_o,
  output logic              illegal_o,
  output logic [4:0]        wr_rd_o
);
  localparam int unsigned NSZ = 4;

  dec_t            dec;
  logic [VLEN-1:0] addend;
  logic [VLEN-1:0] mult_n;
  logic [VLEN-1:0] res_by_sz [NSZ];
  logic [VLEN-1:0] next_res;
  logic            accept;

  logic            out_valid_q;
  logic [VLEN-1:0] res_q;
  logic            wr_en_q;
  logic            illegal_q;
  logic [4:0]      rd_q;

  vmadd_decode u_dec (
    .insn_i (insn_i),
    .dec_o  (dec)
  );

  // destination is addend (role.dst_mul=0) or multiplicand (=1)
  assign addend = dec.role.dst_mul ? zs_i : zd_i;
  assign mult_n = dec.role.dst_mul ? zd_i : zs_i;

  for (genvar s = 0; s < NSZ; s++) begin : g_sz
    vmadd_vec #(.VLEN(VLEN), .W(8 << s)) u_vec (
      .add_i  (addend),
      .n_i    (mult_n),
      .m_i    (zm_i),
      .old_i  (zd_i),
      .pred_i (pred_i),
      .sub_i  (dec.role.sub),
      .res_o  (res_by_sz[s])
    );
  end

  assign next_res = dec.legal ? res_by_sz[dec.esz] : zd_i;

  assign in_ready_o = !out_valid_q || out_ready_i;
  assign accept     = in_valid_i && in_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_q <= 1'b0;
      res_q       <= '0;
      wr_en_q     <= 1'b0;
      illegal_q   <= 1'b0;
      rd_q        <= '0;
    end else if (accept) begin
      out_valid_q <= 1'b1;
      res_q       <= next_res;
      wr_en_q     <= dec.legal;
      illegal_q   <= !dec.legal;
      rd_q        <= dec.rd;
    end else if (out_ready_i) begin
      out_valid_q <= 1'b0;
      wr_en_q     <= 1'b0;
      illegal_q   <= 1'b0;
    end
  end

  assign dec_rd_o      = dec.rd;
  assign dec_rs_o      = dec.rs;
  assign dec_rm_o      = dec.rm;
  assign dec_pg_o      = dec.pg;
  assign dec_role_o    = dec.role;
  assign dec_illegal_o = !dec.legal;
  assign out_valid_o   = out_valid_q;
  assign result_o      = res_q;
  assign wr_en_o       = wr_en_q;
  assign illegal_o     = illegal_q;
  assign wr_rd_o       = rd_q;
endmodule

// File: rtl/vmadd_chk.sv
module vmadd_chk
  import vmadd_pkg::*;
#(
  parameter int unsigned VLEN = 128
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              in_valid_i,
  input logic              in_ready_o,
  input logic [ILEN-1:0]   insn_i,
  input logic [VLEN-1:0]   zd_i,
  input logic [VLEN-1:0]   zs_i,
  input logic [VLEN-1:0]   zm_i,
  input logic [VLEN/8-1:0] pred_i,
  input logic [4:0]        dec_rd_o,
  input logic [4:0]        dec_rs_o,
  input logic [4:0]        dec_rm_o,
  input logic [2:0]        dec_pg_o,
  input logic [1:0]        dec_role_o,
  input logic              dec_illegal_o,
  input logic              out_valid_o,
  input logic              out_ready_i,
  input logic [VLEN-1:0]   result_o,
  input logic              wr_en_o,
  input logic              illegal_o,
  input logic [4:0]        wr_rd_o
);
  // R10
  accept_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && in_ready_o |=> out_valid_o);

  // R10
  stall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(result_o) && $stable(wr_en_o));

  // R1
  illegal_nowrite_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && illegal_o |-> !wr_en_o);

  // R1
  illegal_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && in_ready_o && dec_illegal_o |=> illegal_o && result_o == $past(zd_i));

  // R2
  dest_idx_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && in_ready_o |=> wr_rd_o == $past(insn_i[4:0]));

  // R11
  idle_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_valid_o |-> in_ready_o);
endmodule

bind vmadd_unit vmadd_chk #(.VLEN(VLEN)) u_chk (.*);

// File: tb/vmadd_unit_bench.sv
module vmadd_unit_bench;
  localparam int unsigned VLEN = 128;

  typedef struct packed {
    logic [31:0]     insn;
    logic [VLEN-1:0] zd;
    logic [VLEN-1:0] zs;
    logic [VLEN-1:0] zm;
    logic [15:0]     pred;
    logic [VLEN-1:0] exp;
    logic            wr;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t TBL [NV] = '{
    // R4 bytes: 1+2*3
    '{32'h04004000, {16{8'h01}}, {16{8'h02}}, {16{8'h03}}, 16'hFFFF, {16{8'h07}}, 1'b1},
    // R5 bytes: 1-6 wraps
    '{32'h04006000, {16{8'h01}}, {16{8'h02}}, {16{8'h03}}, 16'hFFFF, {16{8'hFB}}, 1'b1},
    // R6 halves: zs + zd*zm = 0x10+3*4
    '{32'h0440C000, {8{16'h0003}}, {8{16'h0010}}, {8{16'h0004}}, 16'hFFFF, {8{16'h001C}}, 1'b1},
    // R6 words: 0 - 2*3, lowest-byte bits only set
    '{32'h0480E000, {4{32'h2}}, {4{32'h0}}, {4{32'h3}}, 16'h1111, {4{32'hFFFFFFFA}}, 1'b1},
    // R7 words: only non-lowest predicate bits set -> untouched
    '{32'h04804000, {4{32'h12345678}}, {4{32'h1}}, {4{32'h1}}, 16'hEEEE, {4{32'h12345678}}, 1'b1},
    // R8 doubles: lane 0 active 0-(-1), lane 1 inactive
    '{32'h04C06000, 128'h0, {128{1'b1}}, {2{64'h1}}, 16'h0001, 128'h1, 1'b1},
    // R9 bytes: only byte 0 active
    '{32'h04004000, 128'h0, {16{8'h01}}, {16{8'h05}}, 16'h0001, 128'h05, 1'b1},
    // R3 halves wrap: FFFF+1
    '{32'h04404000, {8{16'hFFFF}}, {8{16'h0001}}, {8{16'h0001}}, 16'hFFFF, 128'h0, 1'b1},
    // R1 bad top byte
    '{32'h05004000, {16{8'hA5}}, {16{8'h01}}, {16{8'h01}}, 16'hFFFF, {16{8'hA5}}, 1'b0},
    // R1 bad opcode 000
    '{32'h04000000, {16{8'h3C}}, {16{8'h01}}, {16{8'h01}}, 16'hFFFF, {16{8'h3C}}, 1'b0},
    // R1 bit 21 set
    '{32'h04204000, {16{8'h77}}, {16{8'h01}}, {16{8'h01}}, 16'hFFFF, {16{8'h77}}, 1'b0},
    // R3 doubles: 5 + 2^32*2^32 wraps to 5
    '{32'h04C04000, {2{64'h5}}, {2{64'h1_0000_0000}}, {2{64'h1_0000_0000}}, 16'h0101, {2{64'h5}}, 1'b1}
  };

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic            in_valid_i = 1'b0;
  logic            in_ready_o;
  logic [31:0]     insn_i = '0;
  logic [VLEN-1:0] zd_i = '0;
  logic [VLEN-1:0] zs_i = '0;
  logic [VLEN-1:0] zm_i = '0;
  logic [15:0]     pred_i = '0;
  logic [4:0]      dec_rd_o, dec_rs_o, dec_rm_o, wr_rd_o;
  logic [2:0]      dec_pg_o;
  logic [1:0]      dec_role_o;
  logic            dec_illegal_o, out_valid_o, wr_en_o, illegal_o;
  logic            out_ready_i = 1'b1;
  logic [VLEN-1:0] result_o;

  int checks = 0;
  int fails  = 0;

  always #2 clk_i = ~clk_i;

  vmadd_unit u_vmadd_unit (.*);

  task automatic chk(input string req, input logic [VLEN-1:0] act, input logic [VLEN-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    insn_i = v.insn; zd_i = v.zd; zs_i = v.zs; zm_i = v.zm; pred_i = v.pred;
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R11 reset state
    chk("R11 out_valid", 128'(out_valid_o), 128'd0);
    chk("R11 wr_en", 128'(wr_en_o), 128'd0);
    chk("R11 in_ready", 128'(in_ready_o), 128'd1);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk_i);
      drive(TBL[i]);
      in_valid_i = 1'b1;
      #1;
      chk($sformatf("R1 dec_illegal vec%0d", i), 128'(dec_illegal_o), 128'(!TBL[i].wr));
      @(negedge clk_i);
      in_valid_i = 1'b0;
      chk($sformatf("R10 out_valid vec%0d", i), 128'(out_valid_o), 128'd1);
      chk($sformatf("R4-table result vec%0d", i), result_o, TBL[i].exp);
      chk($sformatf("R1 wr_en vec%0d", i), 128'(wr_en_o), 128'(TBL[i].wr));
      chk($sformatf("R1 illegal vec%0d", i), 128'(illegal_o), 128'(!TBL[i].wr));
    end

    // R2 field decode: rd=1F rs=0A rm=15 pg=5 op=111
    @(negedge clk_i);
    insn_i = 32'h0415F55F;
    #1;
    chk("R2 rd", 128'(dec_rd_o), 128'h1F);
    chk("R2 rs", 128'(dec_rs_o), 128'h0A);
    chk("R2 rm", 128'(dec_rm_o), 128'h15);
    chk("R2 pg", 128'(dec_pg_o), 128'h5);
    chk("R2 role", 128'(dec_role_o), 128'h3);
    insn_i = 32'h04004000;
    #1;
    chk("R2 role add", 128'(dec_role_o), 128'h0);

    // R10 stall with drain and accept on the same edge
    @(negedge clk_i);
    out_ready_i = 1'b0;
    drive(TBL[0]);
    in_valid_i = 1'b1;
    @(negedge clk_i);
    drive(TBL[1]);
    insn_i = 32'h0400601F;  // MLS bytes, rd=31
    #1;
    chk("R10 stalled in_ready", 128'(in_ready_o), 128'd0);
    @(negedge clk_i);
    chk("R10 held result", result_o, TBL[0].exp);
    chk("R10 held valid", 128'(out_valid_o), 128'd1);
    out_ready_i = 1'b1;
    #1;
    chk("R10 ready on drain", 128'(in_ready_o), 128'd1);
    @(negedge clk_i);
    in_valid_i = 1'b0;
    chk("R10 next result", result_o, TBL[1].exp);
    chk("R10 next dest", 128'(wr_rd_o), 128'd31);
    chk("R10 next wr_en", 128'(wr_en_o), 128'd1);
    @(negedge clk_i);
    chk("R10 drained", 128'(out_valid_o), 128'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule